// File: doc/BRIEF.md
# Sequenced Three-Code Lock Controller

This block is a synchronous state machine that unlocks only after three code values arrive in the right order. Each entry is a `W`-bit value on `key_val`, qualified by a one-cycle strobe on `key_stb`. The machine keeps a small constant code table and an equality comparator. Its state picks which stored code the comparator checks, and that choice also appears on `code_sel`.

A correct entry moves the machine one step toward the unlocked state. A wrong entry at any step sends it to a fault state. The unlocked and fault states are both terminal, and only reset leaves them. Outputs are decoded from the registered state alone, so every change shows one clock edge after the strobe that caused it.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the machine returns to the first-code step: `code_sel` = 0, `unlocked` = 0, `fault` = 0 after that edge.
- R2: `code_sel` is 0 while waiting for the first code, 1 for the second and 2 for the third. It is 3 in both the unlocked and the fault state.
- R3: When `key_stb` is high at an edge and `key_val` equals the code for the current step (CODE0, CODE1, CODE2 in that order), the machine moves exactly one step (first→second→third→unlocked), visible after that edge.
- R4: When `key_stb` is high at an edge in any of the three code steps and `key_val` differs from that step's code, the machine enters the fault state after that edge.
- R5: While `key_stb` is low, the state does not change, whatever `key_val` carries.
- R6: `unlocked` is 1 only in the unlocked state.
- R7: `fault` is 1 only in the fault state, and never together with `unlocked`.
- R8: Once unlocked or faulted, the machine ignores every strobe and value until `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| key_val | input | W | Entered code value |
| key_stb | input | 1 | One-cycle strobe marking a fresh entry |
| code_sel | output | 2 | Index of the code under comparison (3 = none) |
| unlocked | output | 1 | Lock is open |
| fault | output | 1 | A wrong entry was seen |

## Verification
A wrong internal state shows up at the ports one edge after the strobe that caused it. The mismatch shows on `code_sel`, `unlocked` or `fault`, because every state has its own output pattern. The bench sweeps every entry value at every step, and it also sends every value into both terminal states. So a wrong next-state arc shows within one cycle of the strobe, and a missed hold shows within the idle cycles checked before it.

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int W = 4,
  parameter logic [W-1:0] CODE0 = W'(3),
  parameter logic [W-1:0] CODE1 = W'(10),
  parameter logic [W-1:0] CODE2 = W'(5)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] key_val,
  input  logic         key_stb,
  output logic [1:0]   code_sel,
  output logic         unlocked,
  output logic         fault
);

  typedef enum logic [2:0] {
    ST_C0   = 3'd0,
    ST_C1   = 3'd1,
    ST_C2   = 3'd2,
    ST_OPEN = 3'd3,
    ST_ERR  = 3'd4
  } state_t;

  state_t st, nxt;
  logic [W-1:0] ref_code;
  logic match, armed;

  assign armed = (st == ST_C0) || (st == ST_C1) || (st == ST_C2);

  always_comb begin
    case (st)
      ST_C0:   ref_code = CODE0;
      ST_C1:   ref_code = CODE1;
      default: ref_code = CODE2;
    endcase
  end

  assign match = armed && (key_val == ref_code);

  always_comb begin
    nxt = st;
    case (st)
      ST_C0, ST_C1, ST_C2:
        if (key_stb) nxt = match ? state_t'(st + 3'd1) : ST_ERR;
      ST_OPEN, ST_ERR: nxt = st;
      default: nxt = ST_C0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_C0;
    else     st <= nxt;
  end

  assign code_sel = armed ? st[1:0] : 2'd3;
  assign unlocked = (st == ST_OPEN);
  assign fault    = (st == ST_ERR);

  assert_reset_R1: assert property (@(posedge clk) rst |=> (code_sel == 2'd0 && !unlocked && !fault));
  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (key_stb && match && st == ST_C2) |=> unlocked);
  assert_wrong_R4: assert property (@(posedge clk) disable iff (rst)
    (key_stb && armed && !match) |=> fault);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !key_stb |=> $stable(st));
  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({unlocked, fault}));
  assert_open_sel_R6: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> code_sel == 2'd3);
  assert_stay_open_R8: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);
  assert_stay_err_R8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

endmodule

// File: tb/combo_lock_tb.sv
module combo_lock_tb_top;
  localparam int W = 4;
  localparam logic [W-1:0] K0 = 4'd3, K1 = 4'd10, K2 = 4'd5;

  logic clk = 0, rst = 1, key_stb = 0;
  logic [W-1:0] key_val = '0;
  logic [1:0] code_sel;
  logic unlocked, fault;
  int checks = 0, fails = 0;

  combo_lock #(.W(W), .CODE0(K0), .CODE1(K1), .CODE2(K2)) dut_i (
    .clk(clk), .rst(rst), .key_val(key_val), .key_stb(key_stb),
    .code_sel(code_sel), .unlocked(unlocked), .fault(fault));

  always #10 clk = ~clk;

  function automatic logic [W-1:0] key_of(int i);
    return (i == 0) ? K0 : (i == 1) ? K1 : K2;
  endfunction

  task automatic expect_st(int idx, string req);
    logic [1:0] es = (idx < 3) ? 2'(idx) : 2'd3;
    logic eu = (idx == 3), ef = (idx == 4);
    checks++;
    if (code_sel !== es || unlocked !== eu || fault !== ef) begin
      fails++;
      $display("FAIL %s: sel/unl/flt = %0d/%0d/%0d expected %0d/%0d/%0d",
               req, code_sel, unlocked, fault, es, eu, ef);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; key_stb = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic enter(logic [W-1:0] v, logic s);
    @(negedge clk); key_val = v; key_stb = s;
    @(negedge clk); key_stb = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    expect_st(0, "R1");
    for (int stage = 0; stage < 3; stage++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset();
        expect_st(0, "R1");
        for (int p = 0; p < stage; p++) begin
          enter(key_of(p), 1);
          expect_st(p + 1, "R3 R2");
        end
        enter(W'(v), 0);
        expect_st(stage, "R5");
        enter(key_of(stage), 0);
        expect_st(stage, "R5");
        enter(W'(v), 1);
        if (W'(v) == key_of(stage)) expect_st(stage + 1, stage == 2 ? "R3 R6" : "R3");
        else                        expect_st(4, "R4 R7");
      end
    end
    for (int v = 0; v < 16; v++) begin
      do_reset();
      enter(K0, 1); enter(K1, 1); enter(K2, 1);
      expect_st(3, "R6");
      enter(W'(v), 1);
      expect_st(3, "R8");
      enter(K0, 1);
      expect_st(3, "R8");
      do_reset();
      enter(K1, 1);
      expect_st(4, "R4");
      enter(W'(v), 1);
      expect_st(4, "R8");
      enter(K0, 1);
      expect_st(4, "R8 R7");
    end
    do_reset();
    expect_st(0, "R1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule